// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital half of a 12-bit successive-approximation converter attached to a microprocessor bus. A bus access is qualified by two enables. When both are asserted, a read/convert select chooses between two actions. One is starting a conversion. The other is driving the last result onto an output bus that is split into three nibbles, each nibble with its own output enable. A byte-address bit is captured when a conversion starts, and it picks between a full 12-bit cycle and a shorter 8-bit cycle. A static format strap chooses how a read presents the result: either as one 12-bit word, or as two bytes on the same eight upper lines.

The internal sequencer works from the most significant bit downward. It tries one bit per clock and drives the trial value to an external DAC as a code. It then samples a one-bit comparator input, which is 1 when the analog input is at or above the DAC level. The block also provides a busy output and two end-of-conversion flags, one for the first eight bits and one for the whole cycle.

Top module: `sar_bus_ctrl`

## Requirements
- R1: No conversion starts and no output enable rises unless both `chip_en` and `chip_sel` are high at the clock edge.
- R2: A convert command (`rd_cnv`=0 with both enables high) seen at an edge while idle makes `busy` high and both `eoc_short` and `eoc_full` low from that edge onward.
- R3: With `addr_lsb`=0 at the start, a full conversion runs: `busy` stays high for exactly 12 clocks. `dac_code` starts at 0x800. Each clock keeps the bit under trial when `cmp_in`=1, clears it when `cmp_in`=0, and sets the next lower bit. The stored result equals the binary-search value of the analog input. While idle, `dac_code` holds its value.
- R4: With `addr_lsb`=1 at the start, a short conversion runs: `busy` stays high for exactly 8 clocks, and the 4 lowest result bits are 0.
- R5: The conversion length is fixed by `addr_lsb` at the start edge. Later changes to `addr_lsb` do not change it.
- R6: After reset, `busy`=0 and both flags are 1. `eoc_short` rises 8 clocks after the start in either length. `eoc_full` rises together with the fall of `busy`, and it is never high while `busy` is high.
- R7: A convert command that arrives while `busy` is high is ignored. The running cycle keeps its length and its result.
- R8: A read that arrives while `busy` is high raises no output enable.
- R9: A read with `fmt_wide`=1 raises `oe_hi`, `oe_mid` and `oe_lo` one clock after the read edge, with `dout` equal to the 12-bit result.
- R10: A read with `fmt_wide`=0 and `addr_lsb`=0 raises `oe_hi` and `oe_mid` only. `dout[11:4]` carries result bits 11..4 and `dout[3:0]` is 0.
- R11: A read with `fmt_wide`=0 and `addr_lsb`=1 raises `oe_hi` and `oe_mid` only. `dout[11:8]` carries result bits 3..0 and `dout[7:0]` is 0.
- R12: When no read was accepted at the previous edge, all three enables and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Access enable, active high |
| chip_sel | input | 1 | Chip select, active high |
| rd_cnv | input | 1 | 1 = read result, 0 = start conversion |
| addr_lsb | input | 1 | Length select at start; byte select on narrow reads |
| fmt_wide | input | 1 | Static strap: 1 = 12-bit word reads, 0 = two byte reads |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | DATA_W | Trial code for the DAC |
| busy | output | 1 | High while a conversion runs |
| eoc_short | output | 1 | High once the top eight bits are decided |
| eoc_full | output | 1 | High once the cycle is complete |
| dout | output | DATA_W | Readout data, zero on disabled nibbles |
| oe_hi | output | 1 | Enable for the top nibble |
| oe_mid | output | 1 | Enable for the middle nibble |
| oe_lo | output | 1 | Enable for the bottom nibble |

## Verification
Conversions are tried with analog values of 0, full scale, and mixed codes such as 0xA5C and 0x5E7. The extremes separate a sequencer that always keeps bits from one that always clears them. The mixed codes expose a wrong bit order or a wrong keep/clear polarity. Short cycles use 0x9AB and 0xFFF, which shows whether the low nibble is left at zero. The same stored result is read as a word, as a high byte and as a low byte, which separates the three steering paths. Convert and read commands are also issued during a conversion, and the address bit is toggled mid-cycle, which separates a latched length from a live one.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WORD = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/sar_cmd_decode.sv
module sar_cmd_decode
  import sar_pkg::*;
(
  input  logic    chip_en,
  input  logic    chip_sel,
  input  logic    rd_cnv,
  input  logic    addr_lsb,
  input  logic    fmt_wide,
  output logic    cnv_req,
  output rd_sel_e rd_sel
);
  logic access;

  assign access  = chip_en & chip_sel;
  assign cnv_req = access & ~rd_cnv;

  always_comb begin
    rd_sel = RD_NONE;
    if (access && rd_cnv) begin
      if (fmt_wide)      rd_sel = RD_WORD;
      else if (addr_lsb) rd_sel = RD_LOW;
      else               rd_sel = RD_HIGH;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              short_sel,
  input  logic              cmp_in,
  output logic              busy,
  output logic              eoc_short,
  output logic              eoc_full,
  output logic [DATA_W-1:0] trial,
  output logic [DATA_W-1:0] result
);
  localparam int IW         = $clog2(DATA_W);
  localparam int SHORT_STOP = DATA_W - SHORT_W;

  logic [IW-1:0]     idx;
  logic              short_q;
  logic [IW-1:0]     stop_idx;
  logic [DATA_W-1:0] decided;
  logic [DATA_W-1:0] next_trial;

  assign stop_idx = short_q ? IW'(SHORT_STOP) : '0;

  always_comb begin
    decided      = trial;
    decided[idx] = cmp_in;
    next_trial   = decided;
    if (idx != '0) next_trial[idx - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      eoc_short <= 1'b1;
      eoc_full  <= 1'b1;
      short_q   <= 1'b0;
      idx       <= '0;
      trial     <= '0;
      result    <= '0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      eoc_short <= 1'b0;
      eoc_full  <= 1'b0;
      short_q   <= short_sel;
      idx       <= IW'(DATA_W - 1);
      trial     <= {1'b1, {(DATA_W-1){1'b0}}};
    end else if (busy) begin
      if (idx == IW'(SHORT_STOP)) eoc_short <= 1'b1;
      if (idx == stop_idx) begin
        busy     <= 1'b0;
        eoc_full <= 1'b1;
        trial    <= decided;
        result   <= decided;
      end else begin
        trial <= next_trial;
        idx   <= idx - IW'(1);
      end
    end
  end
endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_sel_e           rd_sel,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] dout,
  output logic              oe_hi,
  output logic              oe_mid,
  output logic              oe_lo
);
  localparam int NIB_W = DATA_W / 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      oe_hi  <= 1'b0;
      oe_mid <= 1'b0;
      oe_lo  <= 1'b0;
    end else begin
      dout   <= '0;
      oe_hi  <= 1'b0;
      oe_mid <= 1'b0;
      oe_lo  <= 1'b0;
      if (!busy) begin
        case (rd_sel)
          RD_WORD: begin
            dout   <= result;
            oe_hi  <= 1'b1;
            oe_mid <= 1'b1;
            oe_lo  <= 1'b1;
          end
          RD_HIGH: begin
            dout   <= {result[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
            oe_hi  <= 1'b1;
            oe_mid <= 1'b1;
          end
          RD_LOW: begin
            dout   <= {result[NIB_W-1:0], {(DATA_W-NIB_W){1'b0}}};
            oe_hi  <= 1'b1;
            oe_mid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              chip_sel,
  input  logic              rd_cnv,
  input  logic              addr_lsb,
  input  logic              fmt_wide,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] dac_code,
  output logic              busy,
  output logic              eoc_short,
  output logic              eoc_full,
  output logic [DATA_W-1:0] dout,
  output logic              oe_hi,
  output logic              oe_mid,
  output logic              oe_lo
);
  localparam int NIB_W   = DATA_W / 3;
  localparam int SHORT_W = 2 * NIB_W;

  logic              cnv_req;
  rd_sel_e           rd_sel;
  logic [DATA_W-1:0] result;

  sar_cmd_decode u_dec (
    .chip_en  (chip_en),
    .chip_sel (chip_sel),
    .rd_cnv   (rd_cnv),
    .addr_lsb (addr_lsb),
    .fmt_wide (fmt_wide),
    .cnv_req  (cnv_req),
    .rd_sel   (rd_sel)
  );

  sar_seq #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (cnv_req),
    .short_sel (addr_lsb),
    .cmp_in    (cmp_in),
    .busy      (busy),
    .eoc_short (eoc_short),
    .eoc_full  (eoc_full),
    .trial     (dac_code),
    .result    (result)
  );

  sar_readout #(.DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_sel (rd_sel),
    .busy   (busy),
    .result (result),
    .dout   (dout),
    .oe_hi  (oe_hi),
    .oe_mid (oe_mid),
    .oe_lo  (oe_lo)
  );
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dac_code,
  input logic              busy,
  input logic              eoc_short,
  input logic              eoc_full,
  input logic [DATA_W-1:0] dout,
  input logic              oe_hi,
  input logic              oe_mid,
  input logic              oe_lo
);
  localparam int NIB_W = DATA_W / 3;

  assert_flags_low_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!eoc_short && !eoc_full));

  assert_dac_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(dac_code));

  assert_full_flag_vs_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !eoc_full);

  assert_flag_order_R6: assert property (@(posedge clk) disable iff (rst)
    eoc_full |-> eoc_short);

  assert_flag_drop_only_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_full) |-> $rose(busy));

  assert_no_enable_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (oe_hi || oe_mid || oe_lo) |-> $past(!busy));

  assert_low_nibble_word_only_R9: assert property (@(posedge clk) disable iff (rst)
    oe_lo |-> (oe_hi && oe_mid));

  assert_byte_read_pad_R10: assert property (@(posedge clk) disable iff (rst)
    (oe_hi && !oe_lo) |-> (dout[NIB_W-1:0] == '0));

  assert_idle_bus_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !oe_hi |-> (dout == '0 && !oe_mid && !oe_lo));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sar_bus_ctrl_test.sv
`timescale 1ns/1ps
module sar_bus_ctrl_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0, cs = 1'b0, rc = 1'b0, a0 = 1'b0, fmt = 1'b1;
  int           vin = 0;
  logic         cmp;
  logic [W-1:0] dac_code, dout;
  logic         busy, eoc_short, eoc_full, oe_hi, oe_mid, oe_lo;

  int compared = 0;
  int mismatched = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // comparator model: input at or above DAC level
  assign cmp = (vin >= int'(dac_code));

  sar_bus_ctrl #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .chip_en(ce), .chip_sel(cs), .rd_cnv(rc),
    .addr_lsb(a0), .fmt_wide(fmt), .cmp_in(cmp), .dac_code(dac_code),
    .busy(busy), .eoc_short(eoc_short), .eoc_full(eoc_full), .dout(dout),
    .oe_hi(oe_hi), .oe_mid(oe_mid), .oe_lo(oe_lo)
  );

  // behavioural reference model
  int m_busy, m_eoc8, m_eoc12, m_trial, m_res, m_idx, m_short;
  int m_oeh, m_oem, m_oel, m_dout;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_eoc8 = 1; m_eoc12 = 1; m_trial = 0; m_res = 0;
      m_idx = 0; m_short = 0; m_oeh = 0; m_oem = 0; m_oel = 0; m_dout = 0;
    end else begin
      m_oeh = 0; m_oem = 0; m_oel = 0; m_dout = 0;
      if (ce && cs && rc && m_busy == 0) begin
        m_oeh = 1; m_oem = 1;
        if (fmt) begin m_oel = 1; m_dout = m_res; end
        else if (!a0) m_dout = m_res & 'hFF0;
        else m_dout = (m_res & 'hF) << 8;
      end
      if (ce && cs && !rc && m_busy == 0) begin
        m_busy = 1; m_eoc8 = 0; m_eoc12 = 0; m_short = a0;
        m_idx = 11; m_trial = 'h800;
      end else if (m_busy != 0) begin
        if (vin < m_trial) m_trial -= (1 << m_idx);
        if (m_idx == 4) m_eoc8 = 1;
        if (m_idx == (m_short != 0 ? 4 : 0)) begin
          m_busy = 0; m_eoc12 = 1; m_res = m_trial;
        end else begin
          m_idx--; m_trial += (1 << m_idx);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R3 dac_code", int'(dac_code), m_trial);
      chk("R3 busy", int'(busy), m_busy);
      chk("R6 eoc_short", int'(eoc_short), m_eoc8);
      chk("R6 eoc_full", int'(eoc_full), m_eoc12);
      chk("R12 oe_hi", int'(oe_hi), m_oeh);
      chk("R12 oe_mid", int'(oe_mid), m_oem);
      chk("R9 oe_lo", int'(oe_lo), m_oel);
      chk("R9 dout", int'(dout), m_dout);
    end
  end

  task automatic convert(input bit addr, input int v, input bit inject, input bit flip,
                         output int nb, output int e8at, output int e12at);
    @(negedge clk);
    vin = v; ce = 1; cs = 1; rc = 0; a0 = addr;
    nb = 0; e8at = 0; e12at = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      ce = 0; cs = 0;
      if (flip) a0 = ~addr;
      if (inject && k == 3) begin ce = 1; cs = 1; rc = 0; a0 = ~addr; end
      if (busy) nb++;
      if (eoc_short && e8at == 0) e8at = k;
      if (eoc_full && e12at == 0) e12at = k;
    end
    a0 = 0;
  endtask

  task automatic rd(input bit addr, output int d, output int oh, output int om, output int ol);
    @(negedge clk);
    ce = 1; cs = 1; rc = 1; a0 = addr;
    @(negedge clk);
    d = int'(dout); oh = int'(oe_hi); om = int'(oe_mid); ol = int'(oe_lo);
    ce = 0; cs = 0; rc = 0; a0 = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nb, e8, e12, d, oh, om, ol;
    repeat (3) @(negedge clk);
    rst = 0;
    live = 1;
    @(negedge clk);
    // reset state
    chk("R6 reset busy", int'(busy), 0);
    chk("R6 reset flags", int'({eoc_short, eoc_full}), 3);
    chk("R12 reset enables", int'({oe_hi, oe_mid, oe_lo}), 0);

    // R1: one enable missing
    ce = 1; cs = 0; rc = 0;
    @(negedge clk);
    chk("R1 no start without chip_sel", int'(busy), 0);
    ce = 0; cs = 1;
    @(negedge clk);
    chk("R1 no start without chip_en", int'(busy), 0);
    ce = 1; cs = 0; rc = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no read without chip_sel", int'(oe_hi), 0);
    ce = 0; rc = 0;

    // R3 full conversion, R6 flag timing, R9 word read
    fmt = 1;
    convert(0, 'hA5C, 0, 0, nb, e8, e12);
    chk("R3 full busy length", nb, 12);
    chk("R6 eoc_short timing full", e8, 9);
    chk("R6 eoc_full timing full", e12, 13);
    rd(0, d, oh, om, ol);
    chk("R9 word data", d, 'hA5C);
    chk("R9 word enables", oh + om + ol, 3);

    // R8 read during conversion
    @(negedge clk);
    vin = 'h123; ce = 1; cs = 1; rc = 0; a0 = 0;
    @(negedge clk);
    rc = 1;
    @(negedge clk);
    chk("R8 blocked enables", int'({oe_hi, oe_mid, oe_lo}), 0);
    ce = 0; cs = 0; rc = 0;
    repeat (15) @(negedge clk);
    rd(0, d, oh, om, ol);
    chk("R8 later result", d, 'h123);

    // R7 convert while busy is ignored
    convert(0, 'h3C7, 1, 0, nb, e8, e12);
    chk("R7 length unchanged", nb, 12);
    rd(0, d, oh, om, ol);
    chk("R7 result unchanged", d, 'h3C7);

    // R4/R5 short conversion with address toggling
    convert(1, 'h9AB, 0, 1, nb, e8, e12);
    chk("R5 latched short length", nb, 8);
    chk("R6 eoc_short timing short", e8, 9);
    chk("R6 eoc_full timing short", e12, 9);
    rd(0, d, oh, om, ol);
    chk("R4 short result", d, 'h9A0);

    // R10/R11 byte reads
    convert(0, 'h5E7, 0, 0, nb, e8, e12);
    fmt = 0;
    rd(0, d, oh, om, ol);
    chk("R10 high byte data", d, 'h5E0);
    chk("R10 high byte enables", (oh << 2) | (om << 1) | ol, 6);
    rd(1, d, oh, om, ol);
    chk("R11 low byte data", d, 'h700);
    chk("R11 low byte enables", (oh << 2) | (om << 1) | ol, 6);
    @(negedge clk);
    chk("R12 idle after read", int'({oe_hi, oe_mid, oe_lo}) + int'(dout), 0);

    // R3/R4 extremes
    fmt = 1;
    convert(0, 0, 0, 0, nb, e8, e12);
    rd(0, d, oh, om, ol);
    chk("R3 zero input", d, 0);
    convert(0, 4095, 0, 0, nb, e8, e12);
    rd(0, d, oh, om, ol);
    chk("R3 full-scale input", d, 'hFFF);
    convert(1, 4095, 0, 0, nb, e8, e12);
    rd(0, d, oh, om, ol);
    chk("R4 short full-scale", d, 'hFF0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule